// File: doc/BRIEF.md
# UART Interrupt Identification and Priority Encoder

This block decides which of a serial port's five interrupt sources software sees first. It takes the enable bits, the receiver error status, the data-ready and receive-count information, a character-timeout flag, the transmit holding state and the modem-line change bits. From these it forms the 8-bit identification value that a register read returns, along with one active-high interrupt request line. The block also keeps the transmit-empty pending flag and the sticky overrun and break status bits, and updates them from register-access strobes.

The host register decoder sends single-cycle strobes for four accesses: a read of the identification register, a write of the transmit holding register, a read of the line status register, and overrun or break events from the receiver. The identification value and the interrupt line come from registers. A change on a level input shows on them one clock later. A strobe shows two clocks later, because it first updates the flag it acts on.

Top module: `uart_intr_ident`

## Requirements
- R1: After reset the identification low nibble reads 0x1 (nothing pending), the interrupt line is low, and the overrun and break status bits are clear.
- R2: Line status (code 0x6) has the highest priority. It is raised when enable bit 2 is set and any of overrun, parity, framing or break is set. These four bits appear on `lsrErr` at bit 0, 1, 2 and 3 in that order.
- R3: Character timeout (code 0xC) ranks second. It is gated by enable bit 0, the data-available enable, and has no enable bit of its own.
- R4: Data available (code 0x4) ranks third. It is raised when enable bit 0 and data-ready are both set, and either FIFOs are disabled or the receive count is at or above the trigger level.
- R5: Transmit empty (code 0x2) ranks fourth. It is raised when enable bit 1 is set and the transmit-empty pending flag is set.
- R6: Modem status (code 0x0) ranks lowest. It is raised when enable bit 3 is set and any of the four delta bits is set.
- R7: Identification bits 7:6 read 11 while FIFOs are enabled and 00 while they are disabled. Bits 5:4 read 0.
- R8: The interrupt line is registered. It is high exactly when the registered code is not 0x1, and it follows a level-input change after one clock.
- R9: An identification read that returns code 0x2 clears the transmit-empty pending flag. A read that returns any other code leaves the flag unchanged.
- R10: A transmit holding write clears the pending flag. A change of enable bit 1 sets the flag if the new enable is 1 and the holding register is empty, and clears it in every other case.
- R11: When the holding register goes from occupied to empty, the pending flag is set.
- R12: Overrun and break events set sticky status bits. A line status read clears both, unless an event arrives in the same cycle. Parity and framing follow their inputs and are not affected by the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ierVal | input | 4 | Enables: 0 data/timeout, 1 transmit empty, 2 line status, 3 modem |
| fifoEnable | input | 1 | FIFOs enabled |
| dataReady | input | 1 | Receive data ready |
| rxCount | input | CNT_W | Receive FIFO fill level |
| trigLevel | input | CNT_W | Receive trigger level |
| timeoutPend | input | 1 | Character timeout has elapsed |
| parityErr | input | 1 | Parity error level |
| framingErr | input | 1 | Framing error level |
| overrunEvt | input | 1 | Overrun event strobe |
| breakEvt | input | 1 | Break event strobe |
| lsrRead | input | 1 | Line status register read strobe |
| thrEmpty | input | 1 | Transmit holding register empty |
| thrWrite | input | 1 | Transmit holding register write strobe |
| iirRead | input | 1 | Identification register read strobe |
| msrDelta | input | 4 | Modem line change bits |
| iirVal | output | 8 | Identification register value |
| irq | output | 1 | Interrupt request |
| lsrErr | output | 4 | {break, framing, parity, overrun} |

## Verification
The hardest case to reach is an identification read that must leave the transmit-empty flag alone. To get there, the flag is first armed by turning enable bit 1 on while the holding register is empty. A data-available request is then raised, so the read returns code 0x4 and not 0x2. After the read, data-ready is removed, and code 0x2 must appear again. The other flag paths are driven one at a time, each followed by a settle period: the enable toggle with a full holding register, the empty rising edge, and a holding write.

// File: rtl/uart_intr_pkg.sv
package uart_intr_pkg;
  localparam logic [3:0] ID_NONE = 4'h1;
  localparam logic [3:0] ID_LINE = 4'h6;
  localparam logic [3:0] ID_TMO  = 4'hC;
  localparam logic [3:0] ID_RXD  = 4'h4;
  localparam logic [3:0] ID_THR  = 4'h2;
  localparam logic [3:0] ID_MDM  = 4'h0;

  localparam int EN_RXD  = 0;
  localparam int EN_THR  = 1;
  localparam int EN_LINE = 2;
  localparam int EN_MDM  = 3;

  localparam int NUM_SRC = 5;

  typedef struct packed {
    logic thrPend;
    logic ovrFlag;
    logic brkFlag;
  } ctrl_flags_t;
endpackage

// File: rtl/uart_intr_ctrl.sv
module uart_intr_ctrl
  import uart_intr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  ierVal,
  input  logic        thrEmpty,
  input  logic        thrWrite,
  input  logic        iirRead,
  input  logic        lsrRead,
  input  logic        overrunEvt,
  input  logic        breakEvt,
  input  logic [3:0]  curId,
  output ctrl_flags_t flags
);
  logic thrPend;
  logic prevThrEn;
  logic prevThrEmpty;
  logic enChange;
  logic emptyRise;
  logic readHit;
  logic [1:0] stickyEvt;
  logic [1:0] stickyQ;

  assign enChange  = ierVal[EN_THR] != prevThrEn;
  assign emptyRise = thrEmpty && !prevThrEmpty;
  assign readHit   = iirRead && (curId == ID_THR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thrPend      <= 1'b0;
      prevThrEn    <= 1'b0;
      prevThrEmpty <= 1'b1;
    end else begin
      prevThrEn    <= ierVal[EN_THR];
      prevThrEmpty <= thrEmpty;
      if (thrWrite)       thrPend <= 1'b0;
      else if (enChange)  thrPend <= ierVal[EN_THR] && thrEmpty;
      else if (emptyRise) thrPend <= 1'b1;
      else if (readHit)   thrPend <= 1'b0;
    end
  end

  // index 0: overrun, index 1: break
  assign stickyEvt = {breakEvt, overrunEvt};

  for (genvar g = 0; g < 2; g++) begin : gSticky
    always_ff @(posedge clk) begin
      if (!rst_n)            stickyQ[g] <= 1'b0;
      else if (stickyEvt[g]) stickyQ[g] <= 1'b1;
      else if (lsrRead)      stickyQ[g] <= 1'b0;
    end
  end

  assign flags.thrPend = thrPend;
  assign flags.ovrFlag = stickyQ[0];
  assign flags.brkFlag = stickyQ[1];

  assert_thrwr_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    thrWrite |=> !flags.thrPend);

  assert_en_rearm_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (enChange && ierVal[EN_THR] && thrEmpty && !thrWrite) |=> flags.thrPend);

  assert_iir_read_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (readHit && !thrWrite && !enChange && !emptyRise) |=> !flags.thrPend);

  assert_empty_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(thrEmpty) && !thrWrite && !enChange) |=> flags.thrPend);

  assert_lsr_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (lsrRead && !overrunEvt && !breakEvt) |=> (!flags.ovrFlag && !flags.brkFlag));
endmodule

// File: rtl/uart_intr_datapath.sv
module uart_intr_datapath
  import uart_intr_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       ierVal,
  input  ctrl_flags_t      flags,
  input  logic             parityErr,
  input  logic             framingErr,
  input  logic             dataReady,
  input  logic             fifoEnable,
  input  logic [CNT_W-1:0] rxCount,
  input  logic [CNT_W-1:0] trigLevel,
  input  logic             timeoutPend,
  input  logic [3:0]       msrDelta,
  output logic [3:0]       idCode,
  output logic             irq
);
  logic anyLineErr;
  logic [NUM_SRC-1:0] req;        // index 0 is highest priority
  logic [3:0] srcCode [NUM_SRC];
  logic [3:0] idNext;

  assign anyLineErr = flags.ovrFlag || flags.brkFlag || parityErr || framingErr;

  assign req[0] = ierVal[EN_LINE] && anyLineErr;
  assign req[1] = ierVal[EN_RXD] && timeoutPend;
  assign req[2] = ierVal[EN_RXD] && dataReady && (!fifoEnable || (rxCount >= trigLevel));
  assign req[3] = ierVal[EN_THR] && flags.thrPend;
  assign req[4] = ierVal[EN_MDM] && (|msrDelta);

  assign srcCode[0] = ID_LINE;
  assign srcCode[1] = ID_TMO;
  assign srcCode[2] = ID_RXD;
  assign srcCode[3] = ID_THR;
  assign srcCode[4] = ID_MDM;

  always_comb begin
    idNext = ID_NONE;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req[i]) idNext = srcCode[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idCode <= ID_NONE;
      irq    <= 1'b0;
    end else begin
      idCode <= idNext;
      irq    <= (idNext != ID_NONE);
    end
  end

  assert_line_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ierVal[EN_LINE] && (parityErr || framingErr || flags.ovrFlag || flags.brkFlag))
      |=> idCode == ID_LINE);

  assert_tmo_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ierVal[EN_RXD] |=> (idCode != ID_TMO && idCode != ID_RXD));

  assert_rxd_nofifo_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ierVal == 4'b0001 && dataReady && !fifoEnable && !timeoutPend) |=> idCode == ID_RXD);

  assert_mdm_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ierVal[EN_MDM] |=> idCode != ID_MDM);
endmodule

// File: rtl/uart_intr_ident.sv
module uart_intr_ident
  import uart_intr_pkg::*;
#(
  parameter  int FIFO_DEPTH = 16,
  localparam int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       ierVal,
  input  logic             fifoEnable,
  input  logic             dataReady,
  input  logic [CNT_W-1:0] rxCount,
  input  logic [CNT_W-1:0] trigLevel,
  input  logic             timeoutPend,
  input  logic             parityErr,
  input  logic             framingErr,
  input  logic             overrunEvt,
  input  logic             breakEvt,
  input  logic             lsrRead,
  input  logic             thrEmpty,
  input  logic             thrWrite,
  input  logic             iirRead,
  input  logic [3:0]       msrDelta,
  output logic [7:0]       iirVal,
  output logic             irq,
  output logic [3:0]       lsrErr
);
  ctrl_flags_t flags;
  logic [3:0]  idCode;

  uart_intr_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ierVal     (ierVal),
    .thrEmpty   (thrEmpty),
    .thrWrite   (thrWrite),
    .iirRead    (iirRead),
    .lsrRead    (lsrRead),
    .overrunEvt (overrunEvt),
    .breakEvt   (breakEvt),
    .curId      (idCode),
    .flags      (flags)
  );

  uart_intr_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .ierVal      (ierVal),
    .flags       (flags),
    .parityErr   (parityErr),
    .framingErr  (framingErr),
    .dataReady   (dataReady),
    .fifoEnable  (fifoEnable),
    .rxCount     (rxCount),
    .trigLevel   (trigLevel),
    .timeoutPend (timeoutPend),
    .msrDelta    (msrDelta),
    .idCode      (idCode),
    .irq         (irq)
  );

  assign iirVal = {fifoEnable, fifoEnable, 2'b00, idCode};
  assign lsrErr = {flags.brkFlag, framingErr, parityErr, flags.ovrFlag};
endmodule

// File: tb/uart_intr_ident_bench.sv
module uart_intr_ident_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 5;
  localparam int NVEC = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] ierVal = '0;
  logic fifoEnable = 1'b0, dataReady = 1'b0, timeoutPend = 1'b0;
  logic [CNT_W-1:0] rxCount = '0, trigLevel = '0;
  logic parityErr = 1'b0, framingErr = 1'b0, overrunEvt = 1'b0, breakEvt = 1'b0;
  logic lsrRead = 1'b0, thrEmpty = 1'b0, thrWrite = 1'b0, iirRead = 1'b0;
  logic [3:0] msrDelta = '0;
  logic [7:0] iirVal;
  logic irq;
  logic [3:0] lsrErr;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_intr_ident u_uart_intr_ident (
    .clk(clk), .rst_n(rst_n), .ierVal(ierVal), .fifoEnable(fifoEnable),
    .dataReady(dataReady), .rxCount(rxCount), .trigLevel(trigLevel),
    .timeoutPend(timeoutPend), .parityErr(parityErr), .framingErr(framingErr),
    .overrunEvt(overrunEvt), .breakEvt(breakEvt), .lsrRead(lsrRead),
    .thrEmpty(thrEmpty), .thrWrite(thrWrite), .iirRead(iirRead),
    .msrDelta(msrDelta), .iirVal(iirVal), .irq(irq), .lsrErr(lsrErr)
  );

  typedef struct packed {
    logic [3:0] ier;
    logic par;
    logic frm;
    logic dr;
    logic fe;
    logic [4:0] cnt;
    logic [4:0] trig;
    logic tmo;
    logic [3:0] msr;
    logic [7:0] exp;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{4'h0, 1'b1, 1'b0, 1'b1, 1'b0, 5'd0,  5'd1,  1'b1, 4'hF, 8'h01},
    '{4'h4, 1'b1, 1'b0, 1'b0, 1'b1, 5'd0,  5'd1,  1'b0, 4'h0, 8'hC6},
    '{4'hF, 1'b0, 1'b1, 1'b1, 1'b1, 5'd8,  5'd4,  1'b1, 4'h1, 8'hC6},
    '{4'hF, 1'b0, 1'b0, 1'b1, 1'b1, 5'd8,  5'd4,  1'b1, 4'h1, 8'hCC},
    '{4'hE, 1'b0, 1'b0, 1'b1, 1'b1, 5'd8,  5'd4,  1'b1, 4'h2, 8'hC0},
    '{4'h1, 1'b0, 1'b0, 1'b1, 1'b1, 5'd3,  5'd4,  1'b0, 4'h0, 8'hC1},
    '{4'h1, 1'b0, 1'b0, 1'b1, 1'b1, 5'd4,  5'd4,  1'b0, 4'h0, 8'hC4},
    '{4'h1, 1'b0, 1'b0, 1'b1, 1'b0, 5'd0,  5'd14, 1'b0, 4'h0, 8'h04},
    '{4'h1, 1'b0, 1'b0, 1'b0, 1'b1, 5'd14, 5'd1,  1'b0, 4'h0, 8'hC1},
    '{4'h8, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0,  5'd1,  1'b0, 4'h8, 8'h00},
    '{4'h8, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0,  5'd1,  1'b0, 4'h0, 8'h01},
    '{4'h9, 1'b0, 1'b0, 1'b1, 1'b1, 5'd14, 5'd14, 1'b0, 4'h4, 8'hC4}
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1;
    @(negedge clk);
    sig = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 iir", iirVal, 8'h01);
    check("R1 irq", {7'd0, irq}, 8'h00);
    check("R1 lsrErr", {4'd0, lsrErr}, 8'h00);
    rst_n = 1'b1;
    settle();

    // Table: R2 R3 R4 R6 R7 R8 priority and gating
    for (int i = 0; i < NVEC; i++) begin
      ierVal = VECS[i].ier; parityErr = VECS[i].par; framingErr = VECS[i].frm;
      dataReady = VECS[i].dr; fifoEnable = VECS[i].fe; rxCount = VECS[i].cnt;
      trigLevel = VECS[i].trig; timeoutPend = VECS[i].tmo; msrDelta = VECS[i].msr;
      settle();
      check($sformatf("R2/R3/R4/R6/R7 vec%0d iir", i), iirVal, VECS[i].exp);
      check($sformatf("R8 vec%0d irq", i), {7'd0, irq}, {7'd0, VECS[i].exp[3:0] != 4'h1});
    end

    // Clear everything
    ierVal = 4'h0; parityErr = 0; framingErr = 0; dataReady = 0; fifoEnable = 1'b1;
    rxCount = '0; trigLevel = 5'd1; timeoutPend = 0; msrDelta = '0; thrEmpty = 0;
    settle();

    // R8: one-clock latency on a level input
    ierVal = 4'h8; msrDelta = 4'h1;
    check("R8 before edge", {7'd0, irq}, 8'h00);
    @(negedge clk);
    check("R8 after one edge", {7'd0, irq}, 8'h01);
    check("R8 code", iirVal, 8'hC0);
    ierVal = 4'h0; msrDelta = 4'h0;
    settle();

    // R11: empty rising edge sets pending; R5 shows code 0x2
    ierVal = 4'h2;
    settle();
    check("R10 enable with full holding", iirVal, 8'hC1);
    thrEmpty = 1'b1;
    settle();
    check("R11/R5 empty edge", iirVal, 8'hC2);
    check("R5 irq", {7'd0, irq}, 8'h01);

    // R9: read while showing 0x2 clears
    pulse(iirRead);
    settle();
    check("R9 read clears", iirVal, 8'hC1);

    // R10: re-arm via enable toggle while empty
    ierVal = 4'h0; settle();
    ierVal = 4'h2; settle();
    check("R10 rearm", iirVal, 8'hC2);
    pulse(thrWrite);
    settle();
    check("R10 write clears", iirVal, 8'hC1);
    ierVal = 4'h0; settle();
    thrEmpty = 1'b0; settle();
    ierVal = 4'h2; settle();
    check("R10 enable while occupied", iirVal, 8'hC1);

    // R9 negative: read showing another code keeps pending
    ierVal = 4'h0; thrEmpty = 1'b1; settle();
    ierVal = 4'h2; settle();
    ierVal = 4'h3; dataReady = 1'b1; fifoEnable = 1'b0;
    settle();
    check("R9 higher code shown", iirVal, 8'h04);
    pulse(iirRead);
    dataReady = 1'b0;
    settle();
    check("R9 pending kept", iirVal, 8'h02);
    ierVal = 4'h0; fifoEnable = 1'b1; settle();

    // R12: sticky overrun and break
    ierVal = 4'h4;
    pulse(overrunEvt);
    settle();
    check("R12 overrun sticky", {4'd0, lsrErr}, 8'h01);
    check("R2 overrun raises", iirVal, 8'hC6);
    pulse(breakEvt);
    settle();
    check("R12 break sticky", {4'd0, lsrErr}, 8'h09);
    pulse(lsrRead);
    settle();
    check("R12 read clears", {4'd0, lsrErr}, 8'h00);
    check("R12 line cleared", iirVal, 8'hC1);
    parityErr = 1'b1;
    pulse(lsrRead);
    settle();
    check("R12 parity unaffected", {4'd0, lsrErr}, 8'h02);
    parityErr = 1'b0;
    overrunEvt = 1'b1; lsrRead = 1'b1;
    @(negedge clk);
    overrunEvt = 1'b0; lsrRead = 1'b0;
    settle();
    check("R12 event wins over read", {4'd0, lsrErr}, 8'h01);

    // R1: reset returns to idle
    rst_n = 1'b0;
    settle();
    check("R1 reset again", {3'd0, irq, lsrErr}, 8'h00);
    check("R1 reset id", iirVal, 8'hC1);

    done = 1'b1;
    finish_run();
  end
endmodule